// File: doc/BRIEF.md
# Pipeline Flush Reset Sequencer

This block resets a feed-forward datapath without wiring a reset to each of its registers. Only the block's own control state has feedback, so only that state is ever reset. The datapath registers are cleared a different way. A run of zero samples is pushed through them while the result they produce is hidden from the consumer. Seen from outside, the effect is the same as a full reset.

The block sits on both sides of the datapath. Upstream samples pass through it into the datapath, and datapath results pass through it out to the consumer. A sequence starts in two cases: after configuration, when an internal power-on counter is still climbing, and whenever an asynchronous request arrives (it is synchronised first). While a sequence runs, the block sends zeros into the datapath and shows zeros to the consumer. The flush lasts for the pipeline depth plus a safety margin. When it ends, the block releases both paths in the same cycle and raises a single-cycle resume pulse.

Top module: `flush_rst_seq`

## Requirements
- R1: From configuration, `flushing` is high until an internal counter that starts at zero and saturates has reached all ones, and then for FLUSH_LEN = DEPTH + MARGIN further cycles. With the defaults (3-bit counter, DEPTH 4, MARGIN 2), `flushing` first falls at clock edge 13.
- R2: `dp_in` is zero while `flushing` is high and equals `up_data` otherwise.
- R3: `down_data` is zero while `flushing` is high, even if `dp_out` is non-zero, and equals `dp_out` otherwise.
- R4: `ext_rst_req` passes through a two-flop synchroniser. A request first sampled high at edge a raises `flushing` at edge a+2 and has no visible effect before then.
- R5: A request that is high at a single sampling edge keeps `flushing` high for exactly FLUSH_LEN cycles.
- R6: A request that arrives while a flush is in progress reloads the flush counter. `flushing` then stays high for FLUSH_LEN cycles counted from the restart.
- R7: `resume_pulse` is high for exactly one cycle. That cycle is the first one in which `flushing` is low after a sequence, and the pulse appears at no other time.
- R8: After release, a DEPTH-stage datapath delivers only zeros for DEPTH cycles, then fresh samples. No data from before the sequence reaches `down_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_req | input | 1 | Asynchronous reset request, active high |
| up_data | input | DATA_W | Samples from upstream |
| dp_in | output | DATA_W | Gated samples sent into the datapath |
| dp_out | input | DATA_W | Result coming back from the datapath |
| down_data | output | DATA_W | Masked result sent to the consumer |
| flushing | output | 1 | High while a sequence is active |
| resume_pulse | output | 1 | One-cycle pulse when normal operation resumes |

## Verification
A wrong count in the flush counter shows up at the ports as `flushing` falling one or more cycles early or late. The bench sees this at the very edge where release should happen. If the synchroniser has the wrong depth, `flushing` rises at the wrong edge after a request. If the counter is not reloaded on a second request, the flush ends before the restarted window is over. A gate that leaks shows up as non-zero `down_data` while stale data is still leaving the pipeline. A flush that is too short shows up as old samples arriving at `down_data` within DEPTH cycles of release.

// File: rtl/flush_rst_seq.sv
module flush_rst_seq #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int MARGIN = 2,
  parameter int POR_W  = 3
) (
  input  logic              clk,
  input  logic              ext_rst_req,
  input  logic [DATA_W-1:0] up_data,
  output logic [DATA_W-1:0] dp_in,
  input  logic [DATA_W-1:0] dp_out,
  output logic [DATA_W-1:0] down_data,
  output logic              flushing,
  output logic              resume_pulse
);
  localparam int FLUSH_LEN = DEPTH + MARGIN;
  localparam int CNT_W     = $clog2(FLUSH_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FLUSH_LEN - 1);

  logic [POR_W-1:0] por_cnt   = '0;
  logic [1:0]       req_sync  = '0;
  logic             active    = 1'b1;
  logic [CNT_W-1:0] cnt       = CNT_LOAD;
  logic             done_q    = 1'b0;

  wire por_busy = ~&por_cnt;
  wire start    = por_busy | req_sync[1];
  wire last     = active && !start && (cnt == '0);

  always_ff @(posedge clk) begin
    if (por_busy) por_cnt <= por_cnt + 1'b1;
  end

  always_ff @(posedge clk) req_sync <= {req_sync[0], ext_rst_req};

  always_ff @(posedge clk) begin
    if (start) begin
      active <= 1'b1;
      cnt    <= CNT_LOAD;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) done_q <= last;

  assign flushing     = active;
  assign resume_pulse = done_q;
  assign dp_in        = active ? '0 : up_data;
  assign down_data    = active ? '0 : dp_out;

  AST_POR_CLIMBS: assert property (@(posedge clk) disable iff (por_cnt == '0)
    por_busy |=> por_cnt == $past(por_cnt) + 1'b1); // R1
  AST_POR_HOLDS: assert property (@(posedge clk) disable iff (por_cnt == '0)
    por_busy |-> flushing); // R1
  AST_REQ_RELOADS: assert property (@(posedge clk) disable iff (por_cnt == '0)
    req_sync[1] |=> flushing && cnt == CNT_LOAD); // R6
  AST_CNT_STEPS: assert property (@(posedge clk) disable iff (por_cnt == '0)
    (active && !start && cnt != '0) |=> active && cnt == $past(cnt) - 1'b1); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (por_cnt == '0)
    resume_pulse |=> !resume_pulse); // R7
  AST_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (por_cnt == '0)
    resume_pulse |-> $fell(flushing)); // R7
  AST_MASK_OUT: assert property (@(posedge clk) disable iff (por_cnt == '0)
    $rose(flushing) |-> down_data == '0 && dp_in == '0); // R3
endmodule

// File: tb/flush_rst_seq_tb.sv
module flush_rst_seq_tb_top;
  localparam int W = 8;
  localparam int D = 4;
  localparam int L = D + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         ext_rst_req = 1'b0;
  logic [W-1:0] up_data = 8'h5A;
  logic [W-1:0] dp_in, dp_out, down_data;
  logic         flushing, resume_pulse;

  logic [W-1:0] pipe [D];
  always_ff @(posedge clk) begin
    pipe[0] <= dp_in;
    for (int s = 1; s < D; s++) pipe[s] <= pipe[s-1];
  end
  assign dp_out = pipe[D-1];

  flush_rst_seq #(.DATA_W(W), .DEPTH(D), .MARGIN(2), .POR_W(3)) dut_i (
    .clk(clk), .ext_rst_req(ext_rst_req), .up_data(up_data), .dp_in(dp_in),
    .dp_out(dp_out), .down_data(down_data), .flushing(flushing),
    .resume_pulse(resume_pulse));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [W-1:0] VEC [8] = '{8'h11, 8'h22, 8'hF0, 8'h0F, 8'h80, 8'h01, 8'hC3, 8'h7E};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    #1;
    chk(flushing == 1'b1, "R1 flushing at time zero", flushing, 1);
    chk(resume_pulse == 1'b0, "R7 no pulse at time zero", resume_pulse, 0);
    for (int e = 1; e <= 12; e++) begin
      tick();
      chk(flushing == 1'b1, "R1 power-on flush", flushing, 1);
      chk(dp_in == '0, "R2 input forced to zero", dp_in, 0);
      chk(down_data == '0, "R3 output masked", down_data, 0);
      chk(resume_pulse == 1'b0, "R7 no early pulse", resume_pulse, 0);
    end
    tick();
    chk(flushing == 1'b0, "R1 release at edge 13", flushing, 0);
    chk(resume_pulse == 1'b1, "R7 pulse on release", resume_pulse, 1);
    chk(dp_in == 8'h5A, "R2 input passes after release", dp_in, 8'h5A);
    tick();
    chk(resume_pulse == 1'b0, "R7 pulse lasts one cycle", resume_pulse, 0);
    repeat (6) tick();
    chk(down_data == 8'h5A, "R3 output passes after release", down_data, 8'h5A);

    for (int i = 0; i < 8; i++) begin
      up_data = VEC[i];
      tick();
      chk(dp_in == VEC[i], "R2 pass-through input", dp_in, VEC[i]);
      chk(down_data == ((i >= D - 1) ? VEC[i-D+1] : 8'h5A), "R3 pass-through output",
          down_data, (i >= D - 1) ? VEC[i-D+1] : 8'h5A);
    end
    up_data = 8'h5A;
    repeat (D + 2) tick();

    ext_rst_req = 1'b1;
    tick();
    ext_rst_req = 1'b0;
    chk(flushing == 1'b0, "R4 no effect after first sync edge", flushing, 0);
    tick();
    chk(flushing == 1'b0, "R4 no effect after second sync edge", flushing, 0);
    tick();
    chk(flushing == 1'b1, "R4 flush starts two edges after sampling", flushing, 1);
    chk(dp_out == 8'h5A, "R3 stale data present in pipeline", dp_out, 8'h5A);
    chk(down_data == '0, "R3 stale data masked", down_data, 0);
    for (int c = 1; c < L; c++) begin
      tick();
      chk(flushing == 1'b1, "R5 flush length", flushing, 1);
      chk(dp_in == '0, "R2 zeros during request flush", dp_in, 0);
      chk(down_data == '0, "R3 masked during request flush", down_data, 0);
    end
    tick();
    chk(flushing == 1'b0, "R5 flush ends after FLUSH_LEN", flushing, 0);
    chk(resume_pulse == 1'b1, "R7 pulse after request flush", resume_pulse, 1);
    for (int c = 0; c < D - 1; c++) begin
      chk(down_data == '0, "R8 only zeros leave pipeline", down_data, 0);
      tick();
      chk(resume_pulse == 1'b0, "R7 no second pulse", resume_pulse, 0);
    end
    chk(down_data == '0, "R8 only zeros leave pipeline", down_data, 0);
    tick();
    chk(down_data == 8'h5A, "R8 fresh data after DEPTH cycles", down_data, 8'h5A);

    repeat (4) tick();
    ext_rst_req = 1'b1;
    tick();
    ext_rst_req = 1'b0;
    tick();
    tick();
    chk(flushing == 1'b1, "R6 first flush started", flushing, 1);
    repeat (2) tick();
    ext_rst_req = 1'b1;
    tick();
    ext_rst_req = 1'b0;
    tick();
    tick();
    chk(flushing == 1'b1, "R6 restart reloads counter", flushing, 1);
    for (int c = 1; c < L; c++) begin
      tick();
      chk(flushing == 1'b1, "R6 extended flush", flushing, 1);
      chk(resume_pulse == 1'b0, "R7 no pulse during restart", resume_pulse, 0);
    end
    tick();
    chk(flushing == 1'b0, "R6 release after restarted window", flushing, 0);
    chk(resume_pulse == 1'b1, "R7 pulse after restart", resume_pulse, 1);
    tick();
    chk(resume_pulse == 1'b0, "R7 pulse single", resume_pulse, 0);

    finished = 1'b1;
    summary();
  end
endmodule